// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block watches the first bytes of every received HDLC frame and decides, one clock after the address field has been seen, whether the frame is kept and how it is classified. The high address byte is compared against two programmable values and two fixed values (FEh and FCh). The low address byte is compared against a primary value and a second value that acts as a broadcast address. Only a match on the primary registers marks a frame for automatic protocol handling. Any other valid match is kept but passed on transparently.

Bytes arrive on `byte_i`, qualified by `byte_vld_i`. `sof_i` marks the first byte of a frame and `eof_i` marks its last byte. The mode and the address width are sampled with the first byte of each frame. Frame delineation, CRC checking and storage are done by the neighbouring blocks.

Top module: `hdlc_addr_filter`

## Requirements
- R1: The high address byte is compared against `rah1_i`, `rah2_i`, FEh and FCh. On acceptance, `hi_src_o` reports which one matched: 0 for `rah1_i`, 1 for `rah2_i`, 2 for FEh, 3 for FCh.
- R2: When several high-byte compare values equal the received byte, `hi_src_o` follows the priority `rah1_i`, then `rah2_i`, then FEh, then FCh.
- R3: The low address byte is compared against `ral1_i` and `ral2_i`. `lo_bcast_o` is 0 for a `ral1_i` match and 1 for a `ral2_i`-only match. `ral1_i` wins when both are equal.
- R4: In transparent-1 mode (`mode_i`=2), the address field is one high byte only. The frame is accepted when that byte matches. No low byte is compared, so `lo_bcast_o` and `auto_o` stay 0.
- R5: In auto mode (`mode_i`=0) and non-auto mode (`mode_i`=1) with `two_byte_i`=0, the single address byte is compared against the low registers, and `hi_src_o` reads 0.
- R6: In auto and non-auto modes with `two_byte_i`=1, the first byte is the high byte and the second byte is the low byte. The frame is accepted only when both match.
- R7: In auto mode, `auto_o` is 1 only on a `ral1_i` match (1-byte field) or on a `rah1_i` match together with a `ral1_i` match (2-byte field). Every other accepted frame has `auto_o`=0.
- R8: In non-auto mode, every frame whose address matches is accepted, and `auto_o` is always 0.
- R9: `dec_vld_o` pulses for one cycle, one clock after the last address byte. Further bytes of the same frame produce no decision. A new `sof_i` in the middle of an address restarts the field.
- R10: In 2-byte mode, a first byte that also carries `eof_i` gives a rejecting decision one clock later.
- R11: Outside a decision, and on a rejecting decision, `accept_o`, `hi_src_o`, `lo_bcast_o` and `auto_o` are all 0.
- R12: After reset, all outputs are 0.
- R13: `mode_i`=3 rejects every frame with a decision after its first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Byte strobe |
| sof_i | input | 1 | First byte of a frame (qualified by byte_vld_i) |
| eof_i | input | 1 | Last byte of a frame (qualified by byte_vld_i) |
| byte_i | input | 8 | Received byte |
| mode_i | input | 2 | 0 auto, 1 non-auto, 2 transparent-1, 3 reject |
| two_byte_i | input | 1 | 1 selects a 2-byte address field (auto/non-auto) |
| rah1_i | input | 8 | First high-byte compare value |
| rah2_i | input | 8 | Second high-byte compare value |
| ral1_i | input | 8 | Primary low-byte compare value |
| ral2_i | input | 8 | Broadcast low-byte compare value |
| dec_vld_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted |
| hi_src_o | output | 2 | High-byte match source |
| lo_bcast_o | output | 1 | Low byte matched the broadcast value only |
| auto_o | output | 1 | Automatic protocol handling applies |

## Verification
The stimulus walks through these address patterns:

- each of the four high-byte sources in turn, and a byte that matches none;
- equal compare registers, which separates the priority order from a plain match;
- primary, broadcast and mismatching low bytes, in each mode and field width, which separates acceptance from the automatic-handling flag (for example, a 2-byte frame that matches `rah2_i` and `ral1_i`);
- a truncated 2-byte field, trailing data bytes, a restart in the middle of an address, and the reserved mode.

The last group shows that a decision is produced only at the right byte and is clean when it rejects.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
  typedef enum logic [1:0] {
    MD_AUTO    = 2'd0,
    MD_NONAUTO = 2'd1,
    MD_TR1     = 2'd2,
    MD_OFF     = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    HS_RAH1 = 2'd0,
    HS_RAH2 = 2'd1,
    HS_FIXA = 2'd2,
    HS_FIXB = 2'd3
  } hi_src_e;

  typedef enum logic {
    ST_FIRST = 1'b0,
    ST_LOW   = 1'b1
  } addr_st_e;
endpackage

// File: rtl/hdlc_hi_match.sv
module hdlc_hi_match #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] FIX_A = 'hFE,
  parameter logic [W-1:0] FIX_B = 'hFC,
  localparam int unsigned N = 4,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic [W-1:0]  byte_i,
  input  logic [W-1:0]  cmp1_i,
  input  logic [W-1:0]  cmp2_i,
  output logic          hit_o,
  output logic [SW-1:0] src_o
);
  logic [W-1:0] cand [N];

  assign cand[0] = cmp1_i;
  assign cand[1] = cmp2_i;
  assign cand[2] = FIX_A;
  assign cand[3] = FIX_B;

  // lowest index wins: scan from the top, last hit overrides
  always_comb begin
    hit_o = 1'b0;
    src_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (byte_i == cand[i]) begin
        hit_o = 1'b1;
        src_o = SW'(i);
      end
    end
  end
endmodule

// File: rtl/hdlc_lo_match.sv
module hdlc_lo_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] prim_i,
  input  logic [W-1:0] bcast_i,
  output logic         hit_o,
  output logic         bcast_o
);
  logic prim_hit, bc_hit;

  assign prim_hit = (byte_i == prim_i);
  assign bc_hit   = (byte_i == bcast_i);
  assign hit_o    = prim_hit | bc_hit;
  assign bcast_o  = bc_hit & ~prim_hit;
endmodule

// File: rtl/hdlc_addr_ctrl.sv
module hdlc_addr_ctrl
  import hdlc_addr_pkg::*;
#(
  parameter int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          sof_i,
  input  logic          eof_i,
  input  rx_mode_e      mode_i,
  input  logic          two_byte_i,
  input  logic          hi_hit_i,
  input  logic [SW-1:0] hi_src_i,
  input  logic          lo_hit_i,
  input  logic          lo_bcast_i,
  output logic          dec_vld_o,
  output logic          accept_o,
  output logic [SW-1:0] hi_src_o,
  output logic          lo_bcast_o,
  output logic          auto_o
);
  addr_st_e       st_q, st_d;
  rx_mode_e       mode_q, mode_d;
  logic           hhit_q, hhit_d;
  logic [SW-1:0]  hsrc_q, hsrc_d;
  logic           d_dec, d_acc, d_bc, d_auto;
  logic [SW-1:0]  d_src;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    hhit_d = hhit_q;
    hsrc_d = hsrc_q;
    d_dec  = 1'b0;
    d_acc  = 1'b0;
    d_src  = '0;
    d_bc   = 1'b0;
    d_auto = 1'b0;
    if (vld_i && sof_i) begin
      mode_d = mode_i;
      st_d   = ST_FIRST;
      unique case (mode_i)
        MD_TR1: begin
          d_dec = 1'b1;
          d_acc = hi_hit_i;
          d_src = hi_src_i;
        end
        MD_AUTO, MD_NONAUTO: begin
          if (!two_byte_i) begin
            d_dec  = 1'b1;
            d_acc  = lo_hit_i;
            d_bc   = lo_bcast_i;
            d_auto = (mode_i == MD_AUTO) && lo_hit_i && !lo_bcast_i;
          end else if (eof_i) begin
            d_dec = 1'b1;  // truncated address field
          end else begin
            st_d   = ST_LOW;
            hhit_d = hi_hit_i;
            hsrc_d = hi_src_i;
          end
        end
        default: d_dec = 1'b1;
      endcase
    end else if (vld_i && st_q == ST_LOW) begin
      st_d   = ST_FIRST;
      d_dec  = 1'b1;
      d_acc  = hhit_q && lo_hit_i;
      d_src  = hsrc_q;
      d_bc   = lo_bcast_i;
      d_auto = (mode_q == MD_AUTO) && (hsrc_q == SW'(HS_RAH1)) && lo_hit_i && !lo_bcast_i;
    end
    if (!d_acc) begin
      d_src  = '0;
      d_bc   = 1'b0;
      d_auto = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_FIRST;
      mode_q     <= MD_AUTO;
      hhit_q     <= 1'b0;
      hsrc_q     <= '0;
      dec_vld_o  <= 1'b0;
      accept_o   <= 1'b0;
      hi_src_o   <= '0;
      lo_bcast_o <= 1'b0;
      auto_o     <= 1'b0;
    end else begin
      st_q       <= st_d;
      mode_q     <= mode_d;
      hhit_q     <= hhit_d;
      hsrc_q     <= hsrc_d;
      dec_vld_o  <= d_dec;
      accept_o   <= d_acc;
      hi_src_o   <= d_src;
      lo_bcast_o <= d_bc;
      auto_o     <= d_auto;
    end
  end

  AST_NO_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_vld_o |-> !accept_o); // R11
  AST_REJ_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (hi_src_o == '0 && !lo_bcast_o && !auto_o)); // R11
  AST_AUTO_PRIMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o |-> (accept_o && !lo_bcast_o)); // R7
  AST_AUTO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o |-> (mode_q == MD_AUTO)); // R8
  AST_DEC_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(vld_i)); // R9
  AST_WAIT_NO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOW) |-> !dec_vld_o); // R9
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_addr_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] FIX_A = 'hFE,
  parameter logic [W-1:0] FIX_B = 'hFC,
  localparam int unsigned SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_vld_i,
  input  logic          sof_i,
  input  logic          eof_i,
  input  logic [W-1:0]  byte_i,
  input  logic [1:0]    mode_i,
  input  logic          two_byte_i,
  input  logic [W-1:0]  rah1_i,
  input  logic [W-1:0]  rah2_i,
  input  logic [W-1:0]  ral1_i,
  input  logic [W-1:0]  ral2_i,
  output logic          dec_vld_o,
  output logic          accept_o,
  output logic [SW-1:0] hi_src_o,
  output logic          lo_bcast_o,
  output logic          auto_o
);
  logic          hi_hit, lo_hit, lo_bc;
  logic [SW-1:0] hi_src;

  hdlc_hi_match #(.W(W), .FIX_A(FIX_A), .FIX_B(FIX_B)) i_hi_match (
    .byte_i (byte_i),
    .cmp1_i (rah1_i),
    .cmp2_i (rah2_i),
    .hit_o  (hi_hit),
    .src_o  (hi_src)
  );

  hdlc_lo_match #(.W(W)) i_lo_match (
    .byte_i  (byte_i),
    .prim_i  (ral1_i),
    .bcast_i (ral2_i),
    .hit_o   (lo_hit),
    .bcast_o (lo_bc)
  );

  hdlc_addr_ctrl #(.SW(SW)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (byte_vld_i),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .mode_i     (rx_mode_e'(mode_i)),
    .two_byte_i (two_byte_i),
    .hi_hit_i   (hi_hit),
    .hi_src_i   (hi_src),
    .lo_hit_i   (lo_hit),
    .lo_bcast_i (lo_bc),
    .dec_vld_o  (dec_vld_o),
    .accept_o   (accept_o),
    .hi_src_o   (hi_src_o),
    .lo_bcast_o (lo_bcast_o),
    .auto_o     (auto_o)
  );

  AST_TR1_NO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && $past(byte_vld_i && sof_i && mode_i == 2'd2)) |-> (!lo_bcast_o && !auto_o)); // R4
  AST_OFF_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && $past(byte_vld_i && sof_i && mode_i == 2'd3)) |-> !accept_o); // R13
  AST_SHORT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_vld_i && sof_i && eof_i && two_byte_i && !mode_i[1]) |-> (dec_vld_o && !accept_o)); // R10
endmodule

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] mode = 2'd0;
  logic       two = 1'b0;
  logic [7:0] rah1 = 8'h12, rah2 = 8'h34, ral1 = 8'h56, ral2 = 8'h78;
  logic       dec, acc, bc, au;
  logic [1:0] src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .sof_i(sof), .eof_i(eof),
    .byte_i(data), .mode_i(mode), .two_byte_i(two),
    .rah1_i(rah1), .rah2_i(rah2), .ral1_i(ral1), .ral2_i(ral2),
    .dec_vld_o(dec), .accept_o(acc), .hi_src_o(src), .lo_bcast_o(bc), .auto_o(au)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int e_dec, input int e_acc,
                         input int e_src, input int e_bc, input int e_au);
    chk(req, "dec_vld", dec, e_dec);
    chk(req, "accept", acc, e_acc);
    chk(req, "hi_src", src, e_src);
    chk(req, "lo_bcast", bc, e_bc);
    chk(req, "auto", au, e_au);
  endtask

  // drive on falling edge, sample 1 ns after the capturing edge
  task automatic send(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    vld = 1'b1; sof = s; eof = e; data = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk_out("R12", 0, 0, 0, 0, 0);
  endtask

  task automatic t_hi_sources();
    mode = 2'd2;
    send(8'h12, 1, 1); chk_out("R1", 1, 1, 0, 0, 0);
    send(8'h34, 1, 1); chk_out("R1", 1, 1, 1, 0, 0);
    send(8'hFE, 1, 1); chk_out("R1", 1, 1, 2, 0, 0);
    send(8'hFC, 1, 1); chk_out("R1", 1, 1, 3, 0, 0);
    send(8'h56, 1, 1); chk_out("R4", 1, 0, 0, 0, 0);
    idle();
  endtask

  task automatic t_priority();
    mode = 2'd2;
    rah1 = 8'hFE; rah2 = 8'hFE;
    send(8'hFE, 1, 1); chk_out("R2", 1, 1, 0, 0, 0);
    rah1 = 8'h12; rah2 = 8'hFC;
    send(8'hFC, 1, 1); chk_out("R2", 1, 1, 1, 0, 0);
    rah2 = 8'h34; ral1 = 8'h9A; ral2 = 8'h9A; mode = 2'd0; two = 1'b0;
    send(8'h9A, 1, 1); chk_out("R3", 1, 1, 0, 0, 1);
    ral1 = 8'h56; ral2 = 8'h78;
    idle();
  endtask

  task automatic t_transparent_low();
    mode = 2'd2;
    send(8'h12, 1, 0); chk_out("R4", 1, 1, 0, 0, 0);
    send(8'h56, 0, 1); chk_out("R9", 0, 0, 0, 0, 0);
    idle();
  endtask

  task automatic t_one_byte();
    mode = 2'd0; two = 1'b0;
    send(8'h56, 1, 1); chk_out("R5", 1, 1, 0, 0, 1);
    send(8'h78, 1, 1); chk_out("R3", 1, 1, 0, 1, 0);
    send(8'h12, 1, 1); chk_out("R5", 1, 0, 0, 0, 0);
    mode = 2'd1;
    send(8'h56, 1, 1); chk_out("R8", 1, 1, 0, 0, 0);
    send(8'h78, 1, 1); chk_out("R8", 1, 1, 0, 1, 0);
    idle();
  endtask

  task automatic t_two_byte();
    mode = 2'd0; two = 1'b1;
    send(8'h12, 1, 0); chk_out("R9", 0, 0, 0, 0, 0);
    send(8'h56, 0, 0); chk_out("R7", 1, 1, 0, 0, 1);
    send(8'h00, 0, 1); chk_out("R9", 0, 0, 0, 0, 0);
    send(8'h34, 1, 0);
    send(8'h56, 0, 1); chk_out("R7", 1, 1, 1, 0, 0);
    send(8'h12, 1, 0);
    send(8'h78, 0, 1); chk_out("R7", 1, 1, 0, 1, 0);
    send(8'hFE, 1, 0);
    send(8'h56, 0, 1); chk_out("R6", 1, 1, 2, 0, 0);
    send(8'h99, 1, 0);
    send(8'h56, 0, 1); chk_out("R6", 1, 0, 0, 0, 0);
    send(8'h12, 1, 0);
    send(8'h99, 0, 1); chk_out("R6", 1, 0, 0, 0, 0);
    mode = 2'd1;
    send(8'h12, 1, 0);
    send(8'h56, 0, 1); chk_out("R8", 1, 1, 0, 0, 0);
    send(8'hFC, 1, 0);
    send(8'h78, 0, 1); chk_out("R8", 1, 1, 3, 1, 0);
    idle();
  endtask

  task automatic t_short_restart();
    mode = 2'd0; two = 1'b1;
    send(8'h12, 1, 1); chk_out("R10", 1, 0, 0, 0, 0);
    idle(); chk_out("R11", 0, 0, 0, 0, 0);
    send(8'h12, 1, 0);
    send(8'h99, 1, 0); chk_out("R9", 0, 0, 0, 0, 0);
    send(8'h56, 0, 1); chk_out("R9", 1, 0, 0, 0, 0);
    idle();
  endtask

  task automatic t_off_mode();
    mode = 2'd3; two = 1'b0;
    send(8'h56, 1, 1); chk_out("R13", 1, 0, 0, 0, 0);
    mode = 2'd3; two = 1'b1;
    send(8'h12, 1, 0); chk_out("R13", 1, 0, 0, 0, 0);
    send(8'h56, 0, 1); chk_out("R11", 0, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_hi_sources();
    t_priority();
    t_transparent_low();
    t_one_byte();
    t_two_byte();
    t_short_restart();
    t_off_mode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule